// File: doc/BRIEF.md
# Discrete Status Word Serializer

This block builds one 32-bit avionics data word and sends it out serially. The word is made from strapped configuration inputs and sixteen sensed discrete states. It runs from a 1 MHz bit-timing clock. It drives two logic-level line signals, a positive leg and a negative leg, into an external line driver. A busy flag shows when a word is on the line.

A one-cycle start pulse, taken while the block is idle, captures all fields and the speed select in the same clock edge. The block then appends an odd parity bit and sends the 32 bits with return-to-zero encoding, at either the high or the low standard bit rate. The label byte leaves most significant bit first. The data field leaves lowest bit first.

A scheduler outside the block decides when words are due. This block only turns one start pulse into one correctly timed word.

Top module: `a429_word_serializer`

## Requirements
- R1: Transmitted bits 1 to 8 carry the label with label_i[7] first and label_i[0] eighth.
- R2: Transmitted bit 9 carries sd_i[0] and transmitted bit 10 carries sd_i[1].
- R3: Transmitted bits 11 to 26 carry disc_i[0] to disc_i[15] in ascending order.
- R4: Transmitted bits 27 to 31 carry ext_i[0] to ext_i[4] in ascending order; ext_i[3] and ext_i[4] form the sign/status pair (bits 30 and 31).
- R5: Transmitted bit 32 makes the count of ones over all 32 bits odd.
- R6: All fields and fast_i are captured at the clock edge that accepts start_i. Later changes to them have no effect on the word in flight.
- R7: One bit lasts 10 clocks when the captured fast_i is 1 and 80 clocks when it is 0. busy_o rises on the edge that accepts the start and stays high for exactly 32 bit periods.
- R8: For a 1, line_pos_o is high and line_neg_o low during the first half of the bit period. For a 0, line_neg_o is high and line_pos_o low. Both are low in the second half.
- R9: While busy_o is low, both line outputs are low, and a start pulse taken while idle raises busy_o on the next edge.
- R10: A start pulse that arrives while busy_o is high is ignored and does not restart or alter the word.
- R11: An active-low rst_n immediately drives both line outputs and busy_o low and abandons any word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz bit-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| label_i | input | 8 | Label byte |
| sd_i | input | 2 | Source/destination pair (bits 9, 10) |
| disc_i | input | 16 | Sensed discrete states (bits 11 to 26) |
| ext_i | input | 5 | Strapped bits 27 to 31 |
| fast_i | input | 1 | 1 selects the high bit rate, 0 the low bit rate |
| start_i | input | 1 | One-cycle request to send a word |
| line_pos_o | output | 1 | Positive leg, return-to-zero |
| line_neg_o | output | 1 | Negative leg, return-to-zero |
| busy_o | output | 1 | High while a word is being sent |

## Verification
The assertions assume that reset is applied before use and that start_i is a synchronous pulse. They also rely on the speed choice being taken only from the captured copy, so a change on fast_i during a word is legal. The stimulus changes inputs only on falling clock edges and holds start_i for a single cycle. Within that rule, it changes every field and fast_i part way through words. It also raises start_i again mid-word and pulls reset in the first half of a bit, so that the capture, ignore and abort paths are driven within the assumed protocol.

// File: rtl/a429s_pkg.sv
package a429s_pkg;
    localparam int WORD_W  = 32;
    localparam int LABEL_W = 8;
    localparam int SD_W    = 2;
    localparam int DISC_W  = 16;
    localparam int EXT_W   = 5;
    localparam int IDX_W   = $clog2(WORD_W);

    localparam int SD_POS   = LABEL_W;
    localparam int DISC_POS = SD_POS + SD_W;
    localparam int EXT_POS  = DISC_POS + DISC_W;
    localparam int PAR_POS  = EXT_POS + EXT_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             busy;
        logic             fast;
        logic [IDX_W-1:0] idx;
        word_t            shreg;
    } ser_state_t;
endpackage

// File: rtl/a429s_word_build.sv
module a429s_word_build
    import a429s_pkg::*;
(
    input  logic [LABEL_W-1:0] label_i,
    input  logic [SD_W-1:0]    sd_i,
    input  logic [DISC_W-1:0]  disc_i,
    input  logic [EXT_W-1:0]   ext_i,
    output word_t              word_o
);
    // word_o[k] is the bit sent in slot k+1.
    word_t body;

    for (genvar k = 0; k < LABEL_W; k++) begin : g_label
        assign body[k] = label_i[LABEL_W-1-k];
    end
    for (genvar k = 0; k < SD_W; k++) begin : g_sd
        assign body[SD_POS+k] = sd_i[k];
    end
    for (genvar k = 0; k < DISC_W; k++) begin : g_disc
        assign body[DISC_POS+k] = disc_i[k];
    end
    for (genvar k = 0; k < EXT_W; k++) begin : g_ext
        assign body[EXT_POS+k] = ext_i[k];
    end
    assign body[PAR_POS] = 1'b0;

    always_comb begin
        word_o          = body;
        word_o[PAR_POS] = ~(^body[PAR_POS-1:0]);
    end
endmodule

// File: rtl/a429s_bit_timer.sv
module a429s_bit_timer #(
    parameter int FAST_CLKS = 10,
    parameter int SLOW_CLKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic first_half_o,
    output logic bit_end_o
);
    localparam int CW = $clog2(SLOW_CLKS + 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CLKS - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CLKS - 1);
    localparam logic [CW-1:0] FAST_HALF = CW'(FAST_CLKS / 2);
    localparam logic [CW-1:0] SLOW_HALF = CW'(SLOW_CLKS / 2);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last_w, half_w;

    always_comb begin
        last_w       = fast_i ? FAST_LAST : SLOW_LAST;
        half_w       = fast_i ? FAST_HALF : SLOW_HALF;
        bit_end_o    = run_i && (cnt_q == last_w);
        first_half_o = cnt_q < half_w;
        cnt_d        = cnt_q;
        if (!run_i || bit_end_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q <= last_w) else $error("bit counter past period"); // R7
endmodule

// File: rtl/a429_word_serializer.sv
module a429_word_serializer
    import a429s_pkg::*;
#(
    parameter int FAST_CLKS = 10,
    parameter int SLOW_CLKS = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LABEL_W-1:0] label_i,
    input  logic [SD_W-1:0]    sd_i,
    input  logic [DISC_W-1:0]  disc_i,
    input  logic [EXT_W-1:0]   ext_i,
    input  logic               fast_i,
    input  logic               start_i,
    output logic               line_pos_o,
    output logic               line_neg_o,
    output logic               busy_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    ser_state_t s_d, s_q;
    word_t      word_w;
    logic       first_half_w, bit_end_w, last_bit_w;

    a429s_word_build u_build (
        .label_i (label_i),
        .sd_i    (sd_i),
        .disc_i  (disc_i),
        .ext_i   (ext_i),
        .word_o  (word_w)
    );

    a429s_bit_timer #(
        .FAST_CLKS (FAST_CLKS),
        .SLOW_CLKS (SLOW_CLKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (s_q.busy),
        .fast_i       (s_q.fast),
        .first_half_o (first_half_w),
        .bit_end_o    (bit_end_w)
    );

    always_comb begin
        last_bit_w = s_q.idx == LAST_IDX;
        s_d        = s_q;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy  = 1'b1;
                s_d.fast  = fast_i;
                s_d.idx   = '0;
                s_d.shreg = word_w;
            end
        end else if (bit_end_w) begin
            if (last_bit_w) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.idx   = s_q.idx + 1'b1;
                s_d.shreg = s_q.shreg >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o     = s_q.busy;
    assign line_pos_o = s_q.busy & first_half_w &  s_q.shreg[0];
    assign line_neg_o = s_q.busy & first_half_w & ~s_q.shreg[0];

    AST_IDLE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_pos_o && !line_neg_o) else $error("line active while idle"); // R9
    AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos_o && line_neg_o)) else $error("both legs high"); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o) else $error("idle start not taken"); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !(bit_end_w && last_bit_w) |=> busy_o && $stable(s_q.fast))
        else $error("word cut short or speed changed"); // R10
    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> ($countones(s_q.shreg) & 1) == 1)
        else $error("loaded word has even parity"); // R5
endmodule

// File: tb/a429_word_serializer_bench.sv
module a429_word_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  label_i;
    logic [1:0]  sd_i;
    logic [15:0] disc_i;
    logic [4:0]  ext_i;
    logic        fast_i;
    logic        start_i;
    logic        line_pos_o, line_neg_o, busy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    a429_word_serializer u_a429_word_serializer (
        .clk(clk), .rst_n(rst_n), .label_i(label_i), .sd_i(sd_i),
        .disc_i(disc_i), .ext_i(ext_i), .fast_i(fast_i), .start_i(start_i),
        .line_pos_o(line_pos_o), .line_neg_o(line_neg_o), .busy_o(busy_o)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_parity(logic [7:0] lb, logic [1:0] sd,
                                        logic [15:0] ds, logic [4:0] ex);
        return ~(^{lb, sd, ds, ex});
    endfunction

    task automatic send(logic [7:0] lb, logic [1:0] sd, logic [15:0] ds,
                        logic [4:0] ex, bit fast, bit perturb);
        int p = fast ? 10 : 80;
        int h = p / 2;
        logic rx [32];
        int shape_err = 0;
        int busy_err  = 0;
        logic [7:0]  g_lb;
        logic [1:0]  g_sd;
        logic [15:0] g_ds;
        logic [4:0]  g_ex;
        @(negedge clk);
        label_i = lb; sd_i = sd; disc_i = ds; ext_i = ex; fast_i = fast;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < 32 * p; n++) begin
            int k  = n / p;
            int ph = n % p;
            if (perturb && n == 3) begin
                label_i = ~lb; sd_i = ~sd; disc_i = ~ds; ext_i = ~ex; fast_i = ~fast;
            end
            if (perturb && n == p + 2) start_i = 1'b1;
            if (perturb && n == p + 3) start_i = 1'b0;
            if (!busy_o) busy_err++;
            if (ph == 0) rx[k] = line_pos_o;
            if (ph < h) begin
                if (line_pos_o !== rx[k] || line_neg_o !== !rx[k]) shape_err++;
            end else if (line_pos_o || line_neg_o) begin
                shape_err++;
            end
            @(negedge clk);
        end
        for (int k = 0; k < 8; k++)  g_lb[7-k] = rx[k];
        for (int k = 0; k < 2; k++)  g_sd[k]   = rx[8+k];
        for (int k = 0; k < 16; k++) g_ds[k]   = rx[10+k];
        for (int k = 0; k < 5; k++)  g_ex[k]   = rx[26+k];
        chk(g_lb == lb, "R1 label MSB first", 32'(g_lb), 32'(lb));
        chk(g_sd == sd, "R2 sd bits", 32'(g_sd), 32'(sd));
        chk(g_ds == ds, "R3 discrete field", 32'(g_ds), 32'(ds));
        chk(g_ex == ex, "R4 upper bits", 32'(g_ex), 32'(ex));
        chk(rx[31] == exp_parity(lb, sd, ds, ex), "R5 odd parity",
            32'(rx[31]), 32'(exp_parity(lb, sd, ds, ex)));
        chk(shape_err == 0, "R8 return-to-zero shape", 32'(shape_err), 0);
        chk(busy_err == 0 && !busy_o, "R7 busy spans 32 bit periods",
            {busy_err[30:0], busy_o}, 0);
        chk(!line_pos_o && !line_neg_o, "R9 null after word",
            {line_pos_o, line_neg_o}, 0);
        if (perturb) begin
            chk({g_lb, g_sd, g_ds, g_ex} == {lb, sd, ds, ex} && shape_err == 0,
                "R6 R10 capture held through changes and restart",
                {g_ex, g_ds, g_sd, g_lb[0]}, {ex, ds, sd, lb[0]});
        end
        fast_i = fast;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int idle_hi;
        void'($urandom(32'h0429_5EED));
        rst_n = 1'b0; start_i = 1'b0; label_i = '0; sd_i = '0;
        disc_i = '0; ext_i = '0; fast_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !line_pos_o && !line_neg_o, "R11 reset state",
            {busy_o, line_pos_o, line_neg_o}, 0);
        rst_n = 1'b1;

        idle_hi = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (line_pos_o || line_neg_o || busy_o) idle_hi++;
        end
        chk(idle_hi == 0, "R9 idle null without start", 32'(idle_hi), 0);

        send(8'h00, 2'b00, 16'h0000, 5'h00, 1'b1, 1'b0);
        send(8'hFF, 2'b11, 16'hFFFF, 5'h1F, 1'b0, 1'b0);
        send(8'h80, 2'b01, 16'h0001, 5'h18, 1'b1, 1'b0);
        send(8'h01, 2'b10, 16'h8000, 5'h01, 1'b1, 1'b0);
        send(8'hA5, 2'b10, 16'h5A3C, 5'h0B, 1'b1, 1'b1);
        send(8'h3C, 2'b01, 16'hC0DE, 5'h14, 1'b0, 1'b1);

        // R11: abort mid-word during a first half
        @(negedge clk);
        label_i = 8'hFF; fast_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (41) @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk(!busy_o && !line_pos_o && !line_neg_o, "R11 reset aborts word",
            {busy_o, line_pos_o, line_neg_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy_o && !line_pos_o && !line_neg_o, "R11 stays idle after abort",
            {busy_o, line_pos_o, line_neg_o}, 0);

        for (int i = 0; i < 12; i++) begin
            send(8'($urandom), 2'($urandom), 16'($urandom), 5'($urandom),
                 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule